// File: doc/BRIEF.md
# Shared Interrupt Source Router

This block takes a parameterised set of level-sensitive interrupt sources and steers each one onto a single output pin of a single processor context. Every source carries an enable flag, a pending flag, a pin selection and a context selection. An output pin of a context is raised when at least one source routed to that exact context and pin is both enabled and pending. A per-context, per-pin local request vector (already routed and masked upstream) is ORed into the same outputs.

Software configures the router through a simple 32-bit register bus with a one-cycle read latency. It can read pending and enable bitmaps, set or clear enables with write-one semantics, program the pin and context of each source, and force a source's pending flag through a wedge register. Context routing is written and read as a one-hot word, and a zero word leaves the source unrouted.

Top module: `irq_source_router`

## Requirements
- R1: After reset every source is disabled, not pending and unrouted; its pin-map register reads 0x8000_0000 (flag bit 31 set, pin 0); `irq_pin` and `bus_rdata` are 0.
- R2: A source's pending flag takes its input level one cycle after the level changes, whether or not the source is enabled. The pending bitmap word at byte address 0x000 + 4*w holds source 32*w + i in bit i.
- R3: Output bit `irq_pin[v*NUM_PIN + p]` is the OR over all sources that are enabled, pending, routed to context v and mapped to pin p. It is registered: it follows a register write one cycle later and an input level change two cycles later. A disabled source contributes nothing.
- R4: Writing 1 to bit i of the set-enable word at 0x300 + 4*w enables source 32*w + i; writing 1 to the clear-enable word at 0x200 + 4*w disables it; bits written as 0 change nothing. The enable bitmap reads at 0x100 + 4*w with the same bit layout.
- R5: The pin-map register of source s sits at 0x1000 + 4*s with the flag in bit 31 and the pin number in bits [5:0]; a write whose pin number is NUM_PIN or above is dropped.
- R6: The context-map register of source s occupies the 32-byte slot at 0x2000 + 32*s. A non-zero write stores the index of its lowest set bit, a zero write unroutes the source, and a write whose lowest set bit is at or above NUM_VP is dropped. A read returns a one-hot word with the stored index set, or 0 when unrouted.
- R7: A write to the wedge register at 0x400 sets the pending flag of the source numbered in bits [30:0] to bit 31. A source number at or above NUM_SRC is dropped. In the same cycle the wedge wins over a level change.
- R8: Each bit of `local_req` raises the same bit of `irq_pin` one cycle later.
- R9: A read of a source or bitmap word beyond NUM_SRC returns 0, and bitmap bits or map registers beyond NUM_SRC ignore writes.
- R10: `bus_rdata` is loaded in the cycle after `bus_rd` and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 14 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| src_level | input | NUM_SRC | Level of each interrupt source |
| local_req | input | NUM_VP*NUM_PIN | Routed local requests, bit v*NUM_PIN+p |
| irq_pin | output | NUM_VP*NUM_PIN | Registered output pins, bit v*NUM_PIN+p |

## Verification
The assertions take for granted that the bus never asserts `bus_wr` and `bus_rd` together and that each access names a word-aligned address; the bench drives one strobe at a time from tasks and only uses aligned addresses. The wedge property relies on the source number fitting the pending vector index, which holds because it is only checked for in-range numbers. Source levels are changed only at falling edges and held for at least two cycles, so every change is seen by the pending logic before the bench samples the outputs.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 32;
  localparam int PIN_W  = 6;
  localparam int VPI_W  = 5;

  localparam logic [3:0] BLK_PEND  = 4'h0;
  localparam logic [3:0] BLK_EN    = 4'h1;
  localparam logic [3:0] BLK_CLR   = 4'h2;
  localparam logic [3:0] BLK_SET   = 4'h3;
  localparam logic [3:0] BLK_WEDGE = 4'h4;
  localparam logic [ADDR_W-1:0] WEDGE_ADDR = 14'h0400;

  typedef struct packed {
    logic             flag;
    logic [PIN_W-1:0] pin;
  } pin_map_t;

  typedef struct packed {
    logic             valid;
    logic [VPI_W-1:0] idx;
  } vp_map_t;

  function automatic logic [VPI_W-1:0] lowest_set(input logic [DATA_W-1:0] w);
    logic [VPI_W-1:0] r;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (w[i]) r = VPI_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/srt_state.sv
module srt_state
  import srt_pkg::*;
#(
  parameter int NUM_SRC = 256,
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_SRC-1:0] src_level,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] en,
  output pin_map_t          pmap [NUM_SRC],
  output vp_map_t           vmap [NUM_SRC]
);
  logic [NUM_SRC-1:0] lvl_q;
  logic [1:0] unused_lsb;
  assign unused_lsb = addr[1:0];

  logic in_ctrl, clr_hit, set_hit, wedge_hit, pin_hit, vp_hit;
  logic [3:0] blk;
  logic [5:0] word;
  logic [9:0] pin_idx;
  logic [7:0] vp_idx;
  logic [30:0] wedge_src;
  logic wedge_ok, pin_ok, vp_ok;
  logic [VPI_W-1:0] vp_low;

  assign in_ctrl   = (addr[13:12] == 2'b00);
  assign blk       = addr[11:8];
  assign word      = addr[7:2];
  assign clr_hit   = wr && in_ctrl && (blk == BLK_CLR);
  assign set_hit   = wr && in_ctrl && (blk == BLK_SET);
  assign wedge_hit = wr && in_ctrl && (blk == BLK_WEDGE) && (word == 6'd0);
  assign pin_hit   = wr && (addr[13:12] == 2'b01);
  assign vp_hit    = wr && addr[13];
  assign pin_idx   = addr[11:2];
  assign vp_idx    = addr[12:5];
  assign wedge_src = wdata[30:0];
  assign wedge_ok  = wedge_src < 31'(NUM_SRC);
  assign pin_ok    = wdata[5:0] < 6'(NUM_PIN);
  assign vp_low    = lowest_set(wdata);
  assign vp_ok     = (wdata == '0) || ({1'b0, vp_low} < 6'(NUM_VP));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam logic [5:0] WSEL = 6'(s / 32);
    localparam int         BSEL = s % 32;
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q[s] <= 1'b0;
        pend[s]  <= 1'b0;
        en[s]    <= 1'b0;
        pmap[s]  <= '{flag: 1'b1, pin: '0};
        vmap[s]  <= '0;
      end else begin
        lvl_q[s] <= src_level[s];
        if (wedge_hit && wedge_ok && (wedge_src == 31'(s)))
          pend[s] <= wdata[31];
        else if (src_level[s] != lvl_q[s])
          pend[s] <= src_level[s];
        if (set_hit && (word == WSEL) && wdata[BSEL])
          en[s] <= 1'b1;
        else if (clr_hit && (word == WSEL) && wdata[BSEL])
          en[s] <= 1'b0;
        if (pin_hit && (pin_idx == 10'(s)) && pin_ok)
          pmap[s] <= '{flag: wdata[31], pin: wdata[5:0]};
        if (vp_hit && (vp_idx == 8'(s)) && vp_ok)
          vmap[s] <= (wdata == '0) ? '0 : '{valid: 1'b1, idx: vp_low};
      end
    end
  end
endmodule

// File: rtl/srt_route.sv
module srt_route
  import srt_pkg::*;
#(
  parameter int NUM_SRC = 256,
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC-1:0]        en,
  input  pin_map_t                  pmap [NUM_SRC],
  input  vp_map_t                   vmap [NUM_SRC],
  input  logic [NUM_VP*NUM_PIN-1:0] local_req,
  output logic [NUM_VP*NUM_PIN-1:0] irq_pin
);
  localparam int NUM_OUT = NUM_VP * NUM_PIN;
  logic [NUM_OUT-1:0] hit;

  for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      always_comb begin
        hit[v*NUM_PIN+p] = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
          if (en[s] && pend[s] && vmap[s].valid &&
              (vmap[s].idx == VPI_W'(v)) && (pmap[s].pin == PIN_W'(p)))
            hit[v*NUM_PIN+p] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_pin <= '0;
    else     irq_pin <= hit | local_req;
  end
endmodule

// File: rtl/srt_readback.sv
module srt_readback
  import srt_pkg::*;
#(
  parameter int NUM_SRC = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en,
  input  pin_map_t           pmap [NUM_SRC],
  input  vp_map_t            vmap [NUM_SRC],
  output logic [DATA_W-1:0]  rdata
);
  localparam int NWORD = (NUM_SRC + 31) / 32;
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NWORD*32-1:0] pend_pad, en_pad;
  logic [DATA_W-1:0]   nxt;
  logic [5:0]          word;
  logic [9:0]          pin_idx;
  logic [7:0]          vp_idx;
  logic [1:0]          unused_lsb;

  assign unused_lsb = addr[1:0];
  assign word    = addr[7:2];
  assign pin_idx = addr[11:2];
  assign vp_idx  = addr[12:5];

  always_comb begin
    pend_pad = '0;
    en_pad   = '0;
    pend_pad[NUM_SRC-1:0] = pend;
    en_pad[NUM_SRC-1:0]   = en;
  end

  always_comb begin
    nxt = '0;
    if (addr[13:12] == 2'b00) begin
      if ({26'd0, word} < 32'(NWORD)) begin
        if (addr[11:8] == BLK_PEND) nxt = pend_pad[int'(word)*32 +: 32];
        else if (addr[11:8] == BLK_EN) nxt = en_pad[int'(word)*32 +: 32];
      end
    end else if (addr[13:12] == 2'b01) begin
      if ({22'd0, pin_idx} < 32'(NUM_SRC))
        nxt = {pmap[pin_idx[SRC_W-1:0]].flag, 25'd0, pmap[pin_idx[SRC_W-1:0]].pin};
    end else begin
      if ({24'd0, vp_idx} < 32'(NUM_SRC) && vmap[vp_idx[SRC_W-1:0]].valid)
        nxt = 32'd1 << vmap[vp_idx[SRC_W-1:0]].idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= nxt;
  end
endmodule

// File: rtl/irq_source_router.sv
module irq_source_router
  import srt_pkg::*;
#(
  parameter int NUM_SRC = 256,
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NUM_SRC-1:0]        src_level,
  input  logic [NUM_VP*NUM_PIN-1:0] local_req,
  output logic [NUM_VP*NUM_PIN-1:0] irq_pin
);
  logic [NUM_SRC-1:0] pend_q, en_q;
  pin_map_t pmap_q [NUM_SRC];
  vp_map_t  vmap_q [NUM_SRC];

  srt_state #(.NUM_SRC(NUM_SRC), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) u_state (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .src_level(src_level), .pend(pend_q), .en(en_q), .pmap(pmap_q), .vmap(vmap_q)
  );

  srt_route #(.NUM_SRC(NUM_SRC), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) u_route (
    .clk(clk), .rst(rst), .pend(pend_q), .en(en_q), .pmap(pmap_q), .vmap(vmap_q),
    .local_req(local_req), .irq_pin(irq_pin)
  );

  srt_readback #(.NUM_SRC(NUM_SRC)) u_rdbk (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr), .pend(pend_q), .en(en_q),
    .pmap(pmap_q), .vmap(vmap_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/srt_checker.sv
module srt_checker
  import srt_pkg::*;
#(
  parameter int NUM_SRC = 256,
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [NUM_VP*NUM_PIN-1:0] local_req,
  input logic [NUM_VP*NUM_PIN-1:0] irq_pin,
  input logic [NUM_SRC-1:0]        pend,
  input logic [NUM_SRC-1:0]        en
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (irq_pin == '0 && bus_rdata == '0));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    ((en == '0) && (local_req == '0)) |=> (irq_pin == '0));

  a_r8_local_passes: assert property (@(posedge clk) disable iff (rst)
    (local_req != '0) |=> ((irq_pin & $past(local_req)) == $past(local_req)));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  a_r7_wedge_level: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == WEDGE_ADDR) && (bus_wdata[30:0] < 31'(NUM_SRC)))
      |=> (pend[$past(bus_wdata[SRC_W-1:0])] == $past(bus_wdata[31])));
endmodule

bind irq_source_router srt_checker #(.NUM_SRC(NUM_SRC), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .local_req(local_req),
  .irq_pin(irq_pin), .pend(pend_q), .en(en_q)
);

// File: tb/tb_irq_source_router.sv
`timescale 1ns/1ps
module tb_irq_source_router;
  localparam int NS = 256, NV = 4, NP = 6, NO = NV * NP;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NS-1:0] src_level = '0;
  logic [NO-1:0] local_req = '0, irq_pin;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_source_router #(.NUM_SRC(NS), .NUM_VP(NV), .NUM_PIN(NP)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_level(src_level),
    .local_req(local_req), .irq_pin(irq_pin)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic br(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [31:0] pin_out(input int v, input int p);
    logic [31:0] r = '0;
    r[v*NP+p] = 1'b1;
    return r;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq_pin", 32'(irq_pin), 32'h0);
    br(14'h000, d); check("R1 pending word0", d, 32'h0);
    br(14'h100, d); check("R1 enable word0", d, 32'h0);
    br(14'h1000 + 14'(4*7), d); check("R1 pin map", d, 32'h8000_0000);
    br(14'h2000 + 14'(32*7), d); check("R1 vp map", d, 32'h0);
  endtask

  task automatic t_route();
    bw(14'h1000 + 14'(4*5), 32'd2);
    bw(14'h2000 + 14'(32*5), 32'h2);
    bw(14'h300, 32'h20);
    @(negedge clk); src_level[5] = 1'b1;
    @(negedge clk); check("R3 latency one cycle", 32'(irq_pin), 32'h0);
    @(negedge clk); check("R3 routed vp1 pin2", 32'(irq_pin), pin_out(1, 2));
    src_level[5] = 1'b0;
    @(negedge clk); @(negedge clk); check("R3 level drop", 32'(irq_pin), 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    bw(14'h1000 + 14'(4*40), 32'd0);
    bw(14'h2000 + 14'(32*40), 32'h1);
    @(negedge clk); src_level[40] = 1'b1;
    @(negedge clk); @(negedge clk); check("R3 disabled silent", 32'(irq_pin), 32'h0);
    br(14'h004, d); check("R2 pending while disabled", d, 32'h100);
    bw(14'h304, 32'h100);
    @(negedge clk); check("R4 set enable routes", 32'(irq_pin), pin_out(0, 0));
  endtask

  task automatic t_clear();
    logic [31:0] d;
    bw(14'h204, 32'h0);
    br(14'h104, d); check("R4 zero write no effect", d, 32'h100);
    br(14'h100, d); check("R4 other word intact", d, 32'h20);
    bw(14'h204, 32'h100);
    br(14'h104, d); check("R4 clear enable", d, 32'h0);
    check("R4 cleared output", 32'(irq_pin), 32'h0);
    src_level[40] = 1'b0;
  endtask

  task automatic t_pinmap();
    logic [31:0] d;
    bw(14'h1000 + 14'(4*5), 32'd6);
    br(14'h1000 + 14'(4*5), d); check("R5 bad pin dropped", d, 32'h2);
    bw(14'h1000 + 14'(4*5), 32'h8000_0003);
    br(14'h1000 + 14'(4*5), d); check("R5 flag and pin", d, 32'h8000_0003);
  endtask

  task automatic t_vpmap();
    logic [31:0] d;
    bw(14'h2000 + 14'(32*9), 32'hC);
    br(14'h2000 + 14'(32*9), d); check("R6 lowest bit", d, 32'h4);
    bw(14'h2000 + 14'(32*9), 32'h10);
    br(14'h2000 + 14'(32*9), d); check("R6 index too high dropped", d, 32'h4);
    bw(14'h2000 + 14'(32*9), 32'h0);
    br(14'h2000 + 14'(32*9), d); check("R6 zero unroutes", d, 32'h0);
  endtask

  task automatic t_wedge();
    logic [31:0] d;
    bw(14'h1000 + 14'(4*100), 32'd5);
    bw(14'h2000 + 14'(32*100), 32'h8);
    bw(14'h30C, 32'h10);
    bw(14'h400, 32'h8000_0064);
    @(negedge clk); check("R7 wedge raises", 32'(irq_pin), pin_out(3, 5));
    br(14'h00C, d); check("R7 pending set", d, 32'h10);
    bw(14'h400, 32'h0000_0164);
    br(14'h00C, d); check("R7 out of range dropped", d, 32'h10);
    bw(14'h400, 32'h0000_0064);
    @(negedge clk); check("R7 wedge clears", 32'(irq_pin), 32'h0);
  endtask

  task automatic t_share();
    bw(14'h1000 + 14'(4*6), 32'd3);
    bw(14'h2000 + 14'(32*6), 32'h2);
    bw(14'h300, 32'h40);
    bw(14'h400, 32'h8000_0005);
    bw(14'h400, 32'h8000_0006);
    @(negedge clk); check("R3 two sources", 32'(irq_pin), pin_out(1, 3));
    bw(14'h400, 32'h0000_0005);
    @(negedge clk); check("R3 one left", 32'(irq_pin), pin_out(1, 3));
    bw(14'h400, 32'h0000_0006);
    @(negedge clk); check("R3 none left", 32'(irq_pin), 32'h0);
  endtask

  task automatic t_range();
    logic [31:0] d;
    br(14'h1000 + 14'(4*256), d); check("R9 pin map beyond", d, 32'h0);
    br(14'h020, d); check("R9 pending word beyond", d, 32'h0);
    bw(14'h320, 32'hFFFF_FFFF);
    br(14'h120, d); check("R9 enable word beyond", d, 32'h0);
    br(14'h100, d); check("R9 in-range enables intact", d, 32'h60);
  endtask

  task automatic t_local();
    logic [31:0] d;
    @(negedge clk); local_req[13] = 1'b1;
    @(negedge clk); check("R8 local passes", 32'(irq_pin), 32'h2000);
    local_req[13] = 1'b0;
    @(negedge clk); check("R8 local drops", 32'(irq_pin), 32'h0);
    br(14'h1000 + 14'(4*5), d);
    @(negedge clk); @(negedge clk);
    check("R10 rdata holds", bus_rdata, 32'h8000_0003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_route();
    t_disabled();
    t_clear();
    t_pinmap();
    t_vpmap();
    t_wedge();
    t_share();
    t_range();
    t_local();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule